// File: doc/BRIEF.md
# Keyboard Key Event Decoder

This block sits behind a PS/2 keyboard byte receiver and turns its stream of received bytes into key events. Each byte arrives with a one-cycle valid strobe. Bytes that are not prefixes are scan codes. A scan code for a key that is not held is reported as a press. The same code arriving again while the key is still held is the keyboard's periodic resend, and it is reported as a repeat. The release prefix byte (F0h) arms a pending state, and the next scan code is then reported as a release of that key.

The keyboard sends the same scan code whether or not shift is held, so the block keeps its own record of which keys are down. That record is one bit per possible code. From it the block drives a shift level that is high while either shift key (12h or 59h) is held, so a downstream character mapper can pick shifted glyphs. The extended prefix (E0h) is absorbed without any effect. Every event comes out one clock after the byte that caused it, as a single-cycle strobe together with the code.

Top module: `kbd_event_decoder`

## Requirements
- R1: After reset, all event strobes and the shift level are low, and no key is recorded as held, so the first code received for any key reports a press.
- R2: A scan code for a key that is not held raises the press strobe for exactly one cycle, on the clock after the valid byte, with the code output equal to the byte. The key becomes held.
- R3: A scan code for a key that is already held raises the repeat strobe instead of the press strobe, and the key stays held.
- R4: The byte F0h raises no strobe and arms a pending release. The next scan code raises the release strobe with that code and marks the key as no longer held.
- R5: After a release is reported the pending state is clear, so the next scan code of that same key reports a press.
- R6: The byte E0h raises no strobe, and it neither arms nor clears a pending release.
- R7: The shift level is high whenever key 12h or key 59h is held. It falls only once both are released, and it changes on the same clock edge as the strobe that changes the held state.
- R8: At most one strobe is high in any cycle. A strobe is high only on the cycle after a valid byte, and bytes presented while valid is low have no effect.
- R9: A second F0h received while a release is pending raises no strobe, and the release stays pending.
- R10: A release of a key that is not recorded as held still raises the release strobe with its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteIn | input | 8 | Received keyboard byte |
| byteValid | input | 1 | One-cycle qualifier for byteIn |
| evCode | output | 8 | Scan code of the current event |
| pressStb | output | 1 | First press of a key |
| releaseStb | output | 1 | Release of a key |
| repeatStb | output | 1 | Typematic resend of a held key |
| shiftLevel | output | 1 | High while either shift key is held |

## Verification
The assertions assume that the upstream receiver delivers each byte as a single-cycle valid pulse and never sends an unknown value while valid is high. They place no limit on how the bytes are ordered, so break prefixes, extended prefixes and scan codes may arrive in any sequence. The stimulus sends one valid pulse, then drops valid for at least one cycle before the next byte, and it drives byteIn only on falling edges. It sweeps every non-prefix code through the press, repeat and release phases with the prefixes interleaved, and it also holds arbitrary bytes on the input with valid low.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;

  // Strobes from control to datapath, one per decoded byte
  typedef struct packed {
    logic doPress;
    logic doRelease;
    logic doRepeat;
  } evCtrl_t;

  typedef enum logic {
    ST_MAKE  = 1'b0,
    ST_BREAK = 1'b1
  } decState_t;

endpackage

// File: rtl/kbd_evt_ctrl.sv
module kbd_evt_ctrl
  import kbd_evt_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] BREAK_BYTE = 8'hF0,
  parameter logic [CODE_W-1:0] EXT_BYTE = 8'hE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] byteIn,
  input  logic              byteValid,
  input  logic              heldHit,
  output evCtrl_t           ctrl
);

  decState_t state, stateNext;
  logic isBreak, isExt, isCode;

  assign isBreak = byteValid && (byteIn == BREAK_BYTE);
  assign isExt   = byteValid && (byteIn == EXT_BYTE);
  assign isCode  = byteValid && !isBreak && !isExt;

  always_comb begin
    stateNext = state;
    ctrl = '0;
    if (isBreak) begin
      stateNext = ST_BREAK;
    end else if (isCode) begin
      if (state == ST_BREAK) begin
        ctrl.doRelease = 1'b1;
        stateNext = ST_MAKE;
      end else if (heldHit) begin
        ctrl.doRepeat = 1'b1;
      end else begin
        ctrl.doPress = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_MAKE;
    else       state <= stateNext;
  end

  AST_CTRL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrl)) else $error("ctrl strobes overlap"); // R8

  AST_EXT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    isExt |=> $stable(state)) else $error("E0 changed pending state"); // R6

  AST_RELEASE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doRelease |=> state == ST_MAKE) else $error("pending not cleared"); // R5

endmodule

// File: rtl/kbd_evt_datapath.sv
module kbd_evt_datapath
  import kbd_evt_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] SHIFT_L = 8'h12,
  parameter logic [CODE_W-1:0] SHIFT_R = 8'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] byteIn,
  input  logic              byteValid,
  input  evCtrl_t           ctrl,
  output logic              heldHit,
  output logic [CODE_W-1:0] evCode,
  output logic              pressStb,
  output logic              releaseStb,
  output logic              repeatStb,
  output logic              shiftLevel
);

  localparam int NUM_CODES = 1 << CODE_W;

  logic [NUM_CODES-1:0] heldBits;

  assign heldHit = heldBits[byteIn];
  assign shiftLevel = heldBits[SHIFT_L] | heldBits[SHIFT_R];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldBits <= '0;
    end else if (ctrl.doPress) begin
      heldBits[byteIn] <= 1'b1;
    end else if (ctrl.doRelease) begin
      heldBits[byteIn] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evCode     <= '0;
      pressStb   <= 1'b0;
      releaseStb <= 1'b0;
      repeatStb  <= 1'b0;
    end else begin
      pressStb   <= ctrl.doPress;
      releaseStb <= ctrl.doRelease;
      repeatStb  <= ctrl.doRepeat;
      if (ctrl.doPress || ctrl.doRelease || ctrl.doRepeat) evCode <= byteIn;
    end
  end

  AST_PRESS_MARKS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    pressStb |-> heldBits[evCode]) else $error("press left key unheld"); // R2

  AST_REPEAT_KEEPS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    repeatStb |-> heldBits[evCode]) else $error("repeat on unheld key"); // R3

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    releaseStb |-> !heldBits[evCode]) else $error("release left key held"); // R4

  AST_EVENT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (pressStb || releaseStb || repeatStb) |-> $past(byteValid))
    else $error("event without valid byte"); // R8

  AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pressStb, releaseStb, repeatStb})) else $error("strobes overlap"); // R8

endmodule

// File: rtl/kbd_event_decoder.sv
module kbd_event_decoder
  import kbd_evt_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] BREAK_BYTE = 8'hF0,
  parameter logic [CODE_W-1:0] EXT_BYTE = 8'hE0,
  parameter logic [CODE_W-1:0] SHIFT_L = 8'h12,
  parameter logic [CODE_W-1:0] SHIFT_R = 8'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] byteIn,
  input  logic              byteValid,
  output logic [CODE_W-1:0] evCode,
  output logic              pressStb,
  output logic              releaseStb,
  output logic              repeatStb,
  output logic              shiftLevel
);

  evCtrl_t ctrl;
  logic heldHit;

  kbd_evt_ctrl #(
    .CODE_W(CODE_W), .BREAK_BYTE(BREAK_BYTE), .EXT_BYTE(EXT_BYTE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .byteValid(byteValid),
    .heldHit(heldHit), .ctrl(ctrl)
  );

  kbd_evt_datapath #(
    .CODE_W(CODE_W), .SHIFT_L(SHIFT_L), .SHIFT_R(SHIFT_R)
  ) uData (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .byteValid(byteValid),
    .ctrl(ctrl), .heldHit(heldHit), .evCode(evCode), .pressStb(pressStb),
    .releaseStb(releaseStb), .repeatStb(repeatStb), .shiftLevel(shiftLevel)
  );

  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && (byteIn == BREAK_BYTE || byteIn == EXT_BYTE))
      |=> !(pressStb || releaseStb || repeatStb))
    else $error("prefix produced an event"); // R4

  AST_SHIFT_ON_PRESS: assert property (@(posedge clk) disable iff (!rstN)
    ((pressStb || repeatStb) && (evCode == SHIFT_L || evCode == SHIFT_R))
      |-> shiftLevel) else $error("shift low with shift key down"); // R7

endmodule

// File: tb/kbd_event_decoder_test.sv
`timescale 1ns/1ps
module kbd_event_decoder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic byteValid = 1'b0;
  logic [7:0] evCode;
  logic pressStb, releaseStb, repeatStb, shiftLevel;

  int nChecks = 0;
  int nFails = 0;
  bit modelHeld [256];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  kbd_event_decoder uut (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .byteValid(byteValid),
    .evCode(evCode), .pressStb(pressStb), .releaseStb(releaseStb),
    .repeatStb(repeatStb), .shiftLevel(shiftLevel)
  );

  function automatic bit expShift();
    return modelHeld[8'h12] | modelHeld[8'h59];
  endfunction

  // Drive one byte for one cycle; afterwards the registered outputs are settled
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteIn = b;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic expectEv(input string req, input logic [7:0] code,
                          input bit p, input bit r, input bit rp);
    bit codeOk;
    nChecks++;
    codeOk = !(p || r || rp) || (evCode == code);
    if (pressStb !== p || releaseStb !== r || repeatStb !== rp || !codeOk ||
        shiftLevel !== expShift()) begin
      nFails++;
      $display("FAIL %s: got code=%02h p/r/rp=%b%b%b shift=%b, exp code=%02h p/r/rp=%b%b%b shift=%b",
               req, evCode, pressStb, releaseStb, repeatStb, shiftLevel,
               code, p, r, rp, expShift());
    end
  endtask

  function automatic bit isPrefix(input int c);
    return (c == 8'hF0) || (c == 8'hE0);
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expectEv("R1", 8'h00, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    expectEv("R1", 8'h00, 0, 0, 0);

    // R8: bytes with valid low are ignored
    for (int k = 0; k < 4; k++) begin
      byteIn = (k == 0) ? 8'h1C : (k == 1) ? 8'hF0 : (k == 2) ? 8'h12 : 8'hE0;
      @(negedge clk);
      expectEv("R8", 8'h00, 0, 0, 0);
    end
    // A press of 1Ch must still be a press, and shift stays low
    sendByte(8'h1C); modelHeld[8'h1C] = 1;
    expectEv("R8", 8'h1C, 1, 0, 0);
    sendByte(8'hF0); sendByte(8'h1C); modelHeld[8'h1C] = 0;
    expectEv("R8", 8'h1C, 0, 1, 0);

    // R2: first press of every code
    for (int c = 0; c < 256; c++) begin
      if (isPrefix(c)) continue;
      sendByte(8'(c)); modelHeld[c] = 1;
      expectEv("R2", 8'(c), 1, 0, 0);
    end
    // R3: resend while held is a repeat
    for (int c = 0; c < 256; c++) begin
      if (isPrefix(c)) continue;
      sendByte(8'(c));
      expectEv("R3", 8'(c), 0, 0, 1);
    end
    // R4/R6/R7: release with E0 inside the pending window
    for (int c = 0; c < 256; c++) begin
      if (isPrefix(c)) continue;
      sendByte(8'hF0);
      expectEv("R4", 8'h00, 0, 0, 0);
      if (c % 3 == 0) begin
        sendByte(8'hE0);
        expectEv("R6", 8'h00, 0, 0, 0);
      end
      sendByte(8'(c)); modelHeld[c] = 0;
      expectEv((c == 8'h12 || c == 8'h59) ? "R7" : "R4", 8'(c), 0, 1, 0);
    end
    // R5: after release, code is a fresh press
    for (int c = 0; c < 256; c++) begin
      if (isPrefix(c)) continue;
      sendByte(8'(c)); modelHeld[c] = 1;
      expectEv("R5", 8'(c), 1, 0, 0);
    end
    // R9: double break prefix keeps the release pending
    for (int c = 0; c < 256; c++) begin
      if (isPrefix(c)) continue;
      sendByte(8'hF0);
      sendByte(8'hF0);
      expectEv("R9", 8'h00, 0, 0, 0);
      sendByte(8'(c)); modelHeld[c] = 0;
      expectEv("R9", 8'(c), 0, 1, 0);
    end
    // R7: shift held by right key only, then left only
    sendByte(8'h59); modelHeld[8'h59] = 1;
    expectEv("R7", 8'h59, 1, 0, 0);
    sendByte(8'h12); modelHeld[8'h12] = 1;
    expectEv("R7", 8'h12, 1, 0, 0);
    sendByte(8'hF0); sendByte(8'h59); modelHeld[8'h59] = 0;
    expectEv("R7", 8'h59, 0, 1, 0);
    sendByte(8'h1C); modelHeld[8'h1C] = 1;
    expectEv("R7", 8'h1C, 1, 0, 0);
    sendByte(8'hF0); sendByte(8'h12); modelHeld[8'h12] = 0;
    expectEv("R7", 8'h12, 0, 1, 0);
    // R10: release of a key not held
    sendByte(8'hF0); sendByte(8'h2B);
    expectEv("R10", 8'h2B, 0, 1, 0);
    sendByte(8'h1C);
    expectEv("R3", 8'h1C, 0, 0, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule